// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the local-bus side of a host-to-PCI bridge. It converts a local-bus address into a PCI bus address through three programmable windows. Two windows are general purpose. Each has an encoded power-of-two span, a cycle type (interrupt acknowledge, I/O, memory, configuration or memory multiple), a prefetch attribute and a control that sets how PCI address bits 1:0 are produced. The third window always produces I/O cycles and covers a fixed 16 MB span.

Windows may overlap. The lowest-numbered enabled window that matches wins, so software can enlarge window 0 to hide window 1. It can then reprogram window 1 to reach configuration space and restore it afterwards. A lookup is presented with `lb_valid`, and the result appears one clock later, qualified by `xl_valid`. Registers are written through a simple select/data port and read back combinationally.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every window is disabled and every register reads back zero, so no lookup hits.
- R2: Register selects are: 0 = window 0 base, 1 = window 0 map, 2 = window 1 base, 3 = window 1 map, 4 = window 2 base, 5 = window 2 map. Selects 6 and 7 ignore writes and read zero.
- R2 (continued): A general base register keeps bits 31:20 (local base), 9:8 (swap), 7:4 (size code), 3 (prefetch) and 0 (enable). A general map register keeps bits 15:4 (PCI address bits 31:20), 3:1 (cycle type) and 0 (low-bit pass). The window 2 base keeps bits 15:8 (address bits 31:24), 7:6 (swap) and 0 (enable). The window 2 map keeps bits 15:8. All other bits read zero.
- R3: A size code n in 0..11 gives a span of 2^n MB. Codes 12..15 behave as code 11 (2 GB).
- R4: A general window matches when it is enabled and the local address bits above its span equal the same bits of its base. Base bits inside the span are ignored.
- R5: When several windows match, the lowest window number wins, and `win_idx` reports it (0, 1 or 2).
- R6: For a general window, the PCI address takes the map address bits above the span and the local address bits inside the span.
- R7: If the winning general window's low-bit pass bit is 0, PCI address bits 1:0 are 00. If it is 1, they come from the local address.
- R8: A general window reports its map cycle type code (0 = IACK, 1 = I/O, 3 = memory, 5 = configuration, 6 = memory multiple) and its base prefetch bit. Window 2 always reports type 1, prefetch 0 and low-bit pass 1.
- R9: Window 2 matches when it is enabled and local bits 31:24 equal its base bits 15:8. It yields map bits 15:8 followed by local bits 23:0.
- R10: Results appear exactly one cycle after `lb_valid`. A register write in the same cycle as a lookup does not affect that lookup, only later ones.
- R11: When there is no valid result, or the lookup misses, `hit`, `win_idx`, `pci_addr`, `cyc_type`, `prefetch` and `low_pass` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| lb_valid | input | 1 | Lookup request |
| lb_addr | input | 32 | Local-bus address to translate |
| xl_valid | output | 1 | Result valid, one cycle after request |
| hit | output | 1 | Some window matched |
| win_idx | output | 2 | Winning window number |
| pci_addr | output | 32 | Translated PCI address |
| cyc_type | output | 3 | PCI cycle type code |
| prefetch | output | 1 | Winning window is prefetchable |
| low_pass | output | 1 | Address bits 1:0 were passed through |

## Verification
A register write and a lookup can fall in the same clock edge. Reprogramming a window while traffic runs exposes exactly that race. The bench provokes it by disabling window 2 in the same cycle as a lookup into window 2. The scoreboard computes that lookup's expectation from the register contents before the write, and it expects a window 2 hit. It then expects the following lookup to the same address to miss. Window overlap is also exercised by enlarging window 0 over window 1 and reprogramming window 1 for configuration cycles.

// File: rtl/obwin_xlate.sv
module obwin_xlate #(
  parameter int NGEN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lb_valid,
  input  logic [31:0] lb_addr,
  output logic        xl_valid,
  output logic        hit,
  output logic [1:0]  win_idx,
  output logic [31:0] pci_addr,
  output logic [2:0]  cyc_type,
  output logic        prefetch,
  output logic        low_pass
);
  localparam logic [3:0] MAX_SIZE = 4'd11;

  logic [NGEN-1:0][11:0] bbase, mhi;
  logic [NGEN-1:0][1:0]  bswap;
  logic [NGEN-1:0][3:0]  bsize;
  logic [NGEN-1:0][2:0]  mtyp;
  logic [NGEN-1:0]       bpf, ben, mlow;
  logic [7:0]            b2base, m2hi;
  logic [1:0]            b2swap;
  logic                  b2en;

  wire idx = reg_sel[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bbase <= '0; mhi <= '0; bswap <= '0; bsize <= '0; mtyp <= '0;
      bpf <= '0; ben <= '0; mlow <= '0;
      b2base <= '0; m2hi <= '0; b2swap <= '0; b2en <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        3'd0, 3'd2: begin
          bbase[idx] <= reg_wdata[31:20];
          bswap[idx] <= reg_wdata[9:8];
          bsize[idx] <= reg_wdata[7:4];
          bpf[idx]   <= reg_wdata[3];
          ben[idx]   <= reg_wdata[0];
        end
        3'd1, 3'd3: begin
          mhi[idx]  <= reg_wdata[15:4];
          mtyp[idx] <= reg_wdata[3:1];
          mlow[idx] <= reg_wdata[0];
        end
        3'd4: begin
          b2base <= reg_wdata[15:8];
          b2swap <= reg_wdata[7:6];
          b2en   <= reg_wdata[0];
        end
        3'd5: m2hi <= reg_wdata[15:8];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0, 3'd2: reg_rdata = {bbase[idx], 10'b0, bswap[idx], bsize[idx], bpf[idx], 2'b0, ben[idx]};
      3'd1, 3'd3: reg_rdata = {16'b0, mhi[idx], mtyp[idx], mlow[idx]};
      3'd4:       reg_rdata = {16'b0, b2base, b2swap, 5'b0, b2en};
      3'd5:       reg_rdata = {16'b0, m2hi, 8'b0};
      default:    reg_rdata = '0;
    endcase
  end

  logic [NGEN-1:0]       g_hit;
  logic [NGEN-1:0][31:0] g_xa;

  for (genvar w = 0; w < NGEN; w++) begin : g_win
    logic [3:0]  n_eff;
    logic [11:0] keep;
    assign n_eff = (bsize[w] > MAX_SIZE) ? MAX_SIZE : bsize[w];
    assign keep  = 12'hFFF << n_eff;
    assign g_hit[w] = ben[w] && (((lb_addr[31:20] ^ bbase[w]) & keep) == 12'h0);
    assign g_xa[w]  = {(mhi[w] & keep) | (lb_addr[31:20] & ~keep), lb_addr[19:2],
                       mlow[w] ? lb_addr[1:0] : 2'b00};
  end

  wire w2_hit = b2en && (lb_addr[31:24] == b2base);

  logic        n_hit, n_pf, n_lp;
  logic [1:0]  n_idx;
  logic [31:0] n_pa;
  logic [2:0]  n_typ;

  always_comb begin
    n_hit = 1'b0; n_idx = 2'd0; n_pa = '0; n_typ = 3'd0; n_pf = 1'b0; n_lp = 1'b0;
    if (g_hit[0]) begin
      n_hit = 1'b1; n_idx = 2'd0; n_pa = g_xa[0]; n_typ = mtyp[0]; n_pf = bpf[0]; n_lp = mlow[0];
    end else if (g_hit[1]) begin
      n_hit = 1'b1; n_idx = 2'd1; n_pa = g_xa[1]; n_typ = mtyp[1]; n_pf = bpf[1]; n_lp = mlow[1];
    end else if (w2_hit) begin
      n_hit = 1'b1; n_idx = 2'd2; n_pa = {m2hi, lb_addr[23:0]}; n_typ = 3'd1; n_lp = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_valid <= 1'b0; hit <= 1'b0; win_idx <= '0; pci_addr <= '0;
      cyc_type <= '0; prefetch <= 1'b0; low_pass <= 1'b0;
    end else begin
      xl_valid <= lb_valid;
      hit      <= lb_valid & n_hit;
      win_idx  <= lb_valid ? n_idx : 2'd0;
      pci_addr <= lb_valid ? n_pa : 32'd0;
      cyc_type <= lb_valid ? n_typ : 3'd0;
      prefetch <= lb_valid & n_pf;
      low_pass <= lb_valid & n_lp;
    end
  end
endmodule

module obwin_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lb_valid,
  input logic        xl_valid,
  input logic        hit,
  input logic [1:0]  win_idx,
  input logic [31:0] pci_addr,
  input logic [2:0]  cyc_type,
  input logic        prefetch,
  input logic        low_pass
);
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lb_valid |=> xl_valid); // R10
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !lb_valid |=> !xl_valid); // R10
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) hit |-> xl_valid); // R11
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !hit) |-> (pci_addr == 32'd0 && cyc_type == 3'd0 && !prefetch && !low_pass && win_idx == 2'd0)); // R11
  AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (win_idx != 2'd3)); // R5
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_idx == 2'd2) |-> (cyc_type == 3'd1 && !prefetch && low_pass)); // R8
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !low_pass) |-> (pci_addr[1:0] == 2'b00)); // R7
endmodule

bind obwin_xlate obwin_xlate_chk u_chk (.*);

// File: tb/sim_obwin_xlate.sv
`timescale 1ns/1ps
module sim_obwin_xlate;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, lb_valid = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0, lb_addr = '0;
  logic [31:0] reg_rdata, pci_addr;
  logic        xl_valid, hit, prefetch, low_pass;
  logic [1:0]  win_idx;
  logic [2:0]  cyc_type;

  always #2.5 clk = ~clk;

  obwin_xlate u0 (.*);

  int checks = 0, fails = 0;
  logic [39:0] q_exp[$];
  string       q_tag[$];
  logic [31:0] sh_base[2], sh_map[2], sh_b2, sh_m2;

  function automatic logic [39:0] model(input logic [31:0] a);
    for (int i = 0; i < 2; i++) begin
      if (sh_base[i][0]) begin
        int n = int'(sh_base[i][7:4]);
        int s;
        logic [31:0] pa, mp;
        if (n > 11) n = 11;
        s = 20 + n;
        if ((a >> s) == (sh_base[i] >> s)) begin
          mp = {sh_map[i][15:4], 20'b0};
          pa = ((mp >> s) << s) | (a & ((32'd1 << s) - 32'd1));
          if (!sh_map[i][0]) pa[1:0] = 2'b00;
          return {1'b1, 2'(i), pa, sh_map[i][3:1], sh_base[i][3], sh_map[i][0]};
        end
      end
    end
    if (sh_b2[0] && a[31:24] == sh_b2[15:8])
      return {1'b1, 2'd2, sh_m2[15:8], a[23:0], 3'd1, 1'b0, 1'b1};
    return '0;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                      input logic lv, input logic [31:0] la, input string tag);
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd; lb_valid = lv; lb_addr = la;
    if (lv) begin q_exp.push_back(model(la)); q_tag.push_back(tag); end
    if (we) case (sel)
      3'd0: sh_base[0] = wd; 3'd1: sh_map[0] = wd;
      3'd2: sh_base[1] = wd; 3'd3: sh_map[1] = wd;
      3'd4: sh_b2 = wd;      3'd5: sh_m2 = wd;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
    step(1'b1, sel, wd, 1'b0, 32'd0, "");
  endtask

  task automatic look(input logic [31:0] la, input string tag);
    step(1'b0, 3'd0, 32'd0, 1'b1, la, tag);
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_we = 1'b0; lb_valid = 1'b0; reg_sel = sel;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: sel %0d read %h expected %h", tag, sel, reg_rdata, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && xl_valid) begin
      logic [39:0] got, exp;
      string t;
      got = {hit, win_idx, pci_addr, cyc_type, prefetch, low_pass};
      checks++;
      if (q_exp.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected result %h expected none", got);
      end else begin
        exp = q_exp.pop_front(); t = q_tag.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL %s: got hit=%b idx=%0d pa=%h typ=%0d pf=%b lp=%b expected hit=%b idx=%0d pa=%h typ=%0d pf=%b lp=%b",
                   t, got[39], got[38:37], got[36:5], got[4:2], got[1], got[0],
                   exp[39], exp[38:37], exp[36:5], exp[4:2], exp[1], exp[0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    sh_base[0] = 0; sh_base[1] = 0; sh_map[0] = 0; sh_map[1] = 0; sh_b2 = 0; sh_m2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) rd(3'(s), 32'd0, "R1 reset readback");
    look(32'h4000_0000, "R1 miss after reset");
    look(32'h6000_0000, "R11 miss after reset");

    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, 32'hFFF0_03F9, "R2 base0 fields");
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, 32'h0000_FFFF, "R2 map1 fields");
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, 32'h0000_FFC1, "R2 base2 fields");
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, 32'h0000_FF00, "R2 map2 fields");
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, 32'd0, "R2 select 6 ignored");
    rd(3'd0, 32'hFFF0_03F9, "R2 select 6 write left base0 intact");

    wr(3'd0, 32'h4000_0081); wr(3'd1, 32'h0000_0006);
    wr(3'd2, 32'h5000_0089); wr(3'd3, 32'h0100_010D);
    wr(3'd4, 32'h0000_6001); wr(3'd5, 32'h0000_0000);
    look(32'h4123_4567, "R6 R7 window0 memory low bits cleared");
    look(32'h5ABC_DEF3, "R8 window1 prefetch memory multiple");
    look(32'h6012_3457, "R9 window2 I/O");
    look(32'h6100_0000, "R9 window2 16MB upper edge");
    look(32'h3FFF_FFFF, "R4 below window0");
    look(32'h4FFF_FFFF, "R3 window0 last byte");

    wr(3'd0, 32'h4000_0091);
    look(32'h5000_0010, "R5 window0 hides window1");
    wr(3'd2, 32'h6100_0041); wr(3'd3, 32'h0000_000A);
    look(32'h6100_0804, "R8 window1 configuration");
    look(32'h6000_0100, "R5 window2 beneath reprogrammed window1");

    wr(3'd0, 32'h8000_00F1); wr(3'd1, 32'h0000_0006);
    look(32'hFFFF_FFFF, "R3 size code 15 acts as 2GB");
    look(32'h7FFF_FFFF, "R3 below 2GB window");
    wr(3'd0, 32'h8000_00B1);
    look(32'hC000_0003, "R3 size code 11");

    wr(3'd0, 32'h4120_0081); wr(3'd1, 32'h0AB3_0007);
    look(32'h4000_0002, "R4 base bits inside span ignored");
    wr(3'd0, 32'h4120_0080);
    look(32'h4000_0002, "R4 disabled window0 misses");

    step(1'b1, 3'd4, 32'h0000_6000, 1'b1, 32'h6000_0004, "R10 write and lookup same cycle");
    look(32'h6000_0004, "R10 write applies to next lookup");

    step(1'b0, 3'd0, 32'd0, 1'b0, 32'd0, "");
    repeat (3) @(negedge clk);
    checks++;
    if (q_exp.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d results missing expected 0", q_exp.size());
    end
    finish_run();
  end
endmodule